// File: doc/BRIEF.md
# Ternary-Match Multicast Spike Router

This block steers spike-event packets between the on-chip processor ports and six inter-chip links. A packet has an 8-bit header, a 32-bit routing key that names the neuron that fired, and an optional 32-bit payload. Multicast packets are not addressed to a destination. Instead, their key is compared against a table of ternary entries. Each entry holds a key, a care mask and a valid bit. The lowest-numbered entry that matches supplies a destination vector, and the packet is offered on every destination in that vector in the same step.

When no entry matches, the packet travels straight on through the link opposite the one it arrived on. A miss on a packet from a local core has no such default, so it is reported and discarded. Other packet kinds leave on a separate bypass port untouched. Before any routing, a packet is discarded if its 2-bit timestamp shows it has outlived its window relative to a global phase. A multicast packet is also discarded if it fails odd parity. Each kind of discard has its own counter.

Software-side writes reach the table through a one-cycle write port. Each output has a valid/ready handshake. The router holds a packet until every selected destination has taken it, and accepts nothing new while it waits.

Top module: `mc_router`

## Requirements
- R1: Header layout is type in bits 7:6 (00 multicast, 01 point-to-point, 10 nearest-neighbour, 11 fixed-route), timestamp in bits 5:4, payload-present flag in bit 1 and parity in bit 0. A non-multicast packet that is not stale appears only on the bypass port, with header, key and payload unchanged and without a parity check.
- R2: A packet of any type whose timestamp equals (phase_i + 2) mod 4 is discarded with no output, and `age_drops_o` increments by one. This check comes before every other check.
- R3: A non-stale multicast packet must have an odd number of ones over header, key and payload. The payload counts only when bit 1 of the header is set. A failing packet is discarded and `par_drops_o` increments by one.
- R4: An entry matches when its valid bit is set and the key equals the entry key in every position where the mask bit is 1. Positions where the mask bit is 0 are don't-care.
- R5: When several entries match, the entry with the lowest index decides the route.
- R6: On a hit, `dest_valid_o` equals the entry's destination vector, and all of its bits rise together in the cycle after acceptance. Bit i for i<6 is link i, and bit 6+j is core port j.
- R7: A multicast miss from link s (in_src_i 0..5) is offered only on link (s+3) mod 6.
- R8: A multicast miss from a local core (in_src_i 6 or 7) is discarded, and `err_o` pulses high for exactly the one cycle after acceptance.
- R9: Each destination's valid stays high until that destination's ready is seen, then drops. The output data stay stable, and `in_ready_o` stays low until every selected destination has accepted.
- R10: A table write takes effect at the clock edge. A packet accepted in the same cycle as the write is routed by the old entry contents, and later packets use the new ones.
- R11: After reset, `in_ready_o` is high, no output valid is set, both counters are zero, `err_o` is low, and every table entry is invalid.
- R12: A hit on an entry whose destination vector is all zero discards the packet silently, without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Global time phase for the age check |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_valid_i | input | 1 | Valid bit written to the entry |
| wr_key_i | input | 32 | Entry key |
| wr_mask_i | input | 32 | Entry care mask (1 = compare) |
| wr_dest_i | input | NDEST | Entry destination vector |
| in_valid_i | input | 1 | Input packet valid |
| in_ready_o | output | 1 | Router can accept a packet |
| in_src_i | input | 3 | Arrival port: 0..5 link, 6..7 local core |
| in_hdr_i | input | 8 | Packet header |
| in_key_i | input | 32 | Routing key |
| in_pay_i | input | 32 | Payload |
| out_hdr_o | output | 8 | Header of held packet |
| out_key_o | output | 32 | Key of held packet |
| out_pay_o | output | 32 | Payload of held packet |
| dest_valid_o | output | NDEST | Per-destination valid |
| dest_ready_i | input | NDEST | Per-destination ready |
| byp_valid_o | output | 1 | Bypass port valid |
| byp_ready_i | input | 1 | Bypass port ready |
| err_o | output | 1 | Pulse for local-core miss |
| age_drops_o | output | CNT_W | Count of stale discards |
| par_drops_o | output | CNT_W | Count of parity discards |

## Verification
Lookup, the age and parity decisions and the counter updates all complete at the clock edge where the packet is accepted. Destination valids, output data, counter values and the error pulse are therefore all due one cycle after that edge. The bench drives inputs on the falling edge and reads the results on the next falling edge, half a cycle after they settle. After that, it releases random ready patterns one cycle at a time and checks, at each falling edge, that the remaining valids equal the destinations that have not yet taken the packet. It also checks in each of those cycles that `in_ready_o` is still low. The expected route of each packet comes from a reference table kept in the bench and updated in step with every write.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
  localparam int unsigned NUM_LINKS = 6;

  typedef enum logic [1:0] {
    PT_MC  = 2'b00,
    PT_P2P = 2'b01,
    PT_NN  = 2'b10,
    PT_FR  = 2'b11
  } pkt_kind_e;

  typedef struct packed {
    logic [7:0]  hdr;
    logic [31:0] key;
    logic [31:0] pay;
  } pkt_t;

  // odd parity over header, key and (if flagged) payload
  function automatic logic parity_ok(pkt_t p);
    logic [31:0] pm;
    pm = p.hdr[1] ? p.pay : 32'h0;
    return ^{p.hdr, p.key, pm};
  endfunction

  function automatic logic is_stale(logic [1:0] ts, logic [1:0] ph);
    logic [1:0] lim;
    lim = ph + 2'd2;
    return ts == lim;
  endfunction

  function automatic logic [NUM_LINKS-1:0] opposite(logic [2:0] s);
    logic [2:0] o;
    logic [NUM_LINKS-1:0] r;
    if (s < 3'd3) o = s + 3'd3;
    else          o = s - 3'd3;
    r    = '0;
    r[o] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mcr_table.sv
`timescale 1ns/1ps
module mcr_table #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 10,
  parameter int unsigned KW    = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [KW-1:0]    wr_key_i,
  input  logic [KW-1:0]    wr_mask_i,
  input  logic [DW-1:0]    wr_dest_i,
  input  logic [KW-1:0]    lk_key_i,
  output logic [DEPTH-1:0] hit_o,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [DW-1:0]    rd_dest_o
);
  logic [KW-1:0]    key_q  [DEPTH];
  logic [KW-1:0]    mask_q [DEPTH];
  logic [DW-1:0]    dest_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      key_q[wr_idx_i]  <= wr_key_i;
      mask_q[wr_idx_i] <= wr_mask_i;
      dest_q[wr_idx_i] <= wr_dest_i;
    end
  end

  // one match line per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_o[g] = vld_q[g] & ~|((lk_key_i ^ key_q[g]) & mask_q[g]);
  end

  assign rd_dest_o = dest_q[rd_idx_i];

  // R10
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx_i)] == $past(wr_valid_i)));
endmodule

// File: rtl/mcr_prio.sv
`timescale 1ns/1ps
module mcr_prio #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  logic [N-1:0] below_m;
  assign below_m = (N'(1) << idx_o) - N'(1);

  // R5
  lowest_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (req_i[idx_o] && ((req_i & below_m) == '0)));
endmodule

// File: rtl/mcr_outq.sv
`timescale 1ns/1ps
module mcr_outq import mcr_pkg::*; #(
  parameter int unsigned NO = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NO-1:0] load_sel_i,
  input  pkt_t          pkt_i,
  input  logic [NO-1:0] ready_i,
  output logic [NO-1:0] valid_o,
  output pkt_t          pkt_o,
  output logic          busy_o
);
  logic [NO-1:0] pend_q;
  pkt_t          pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      pkt_q  <= '0;
    end else if (load_i) begin
      pend_q <= load_sel_i;
      pkt_q  <= pkt_i;
    end else begin
      pend_q <= pend_q & ~ready_i;
    end
  end

  assign valid_o = pend_q;
  assign pkt_o   = pkt_q;
  assign busy_o  = |pend_q;

  // R9
  shrink_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((valid_o & ~$past(valid_o)) == '0));
  // R9
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(pkt_o));
  // R9
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/mc_router.sv
`timescale 1ns/1ps
module mc_router import mcr_pkg::*; #(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned NDEST    = NUM_LINKS + NUM_CORES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       phase_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [31:0]      wr_key_i,
  input  logic [31:0]      wr_mask_i,
  input  logic [NDEST-1:0] wr_dest_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [2:0]       in_src_i,
  input  logic [7:0]       in_hdr_i,
  input  logic [31:0]      in_key_i,
  input  logic [31:0]      in_pay_i,
  output logic [7:0]       out_hdr_o,
  output logic [31:0]      out_key_o,
  output logic [31:0]      out_pay_o,
  output logic [NDEST-1:0] dest_valid_o,
  input  logic [NDEST-1:0] dest_ready_i,
  output logic             byp_valid_o,
  input  logic             byp_ready_i,
  output logic             err_o,
  output logic [CNT_W-1:0] age_drops_o,
  output logic [CNT_W-1:0] par_drops_o
);
  localparam int unsigned NO = NDEST + 1;

  pkt_t             in_pkt, out_pkt;
  logic [DEPTH-1:0] hit_vec;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [NDEST-1:0] hit_dest;
  logic             busy, accept;
  logic [NO-1:0]    route_sel, out_vld, out_rdy;
  logic             drop_age, drop_par, local_miss, miss_fwd;
  logic [CNT_W-1:0] age_q, par_q;
  logic             err_q;

  assign in_pkt = '{hdr: in_hdr_i, key: in_key_i, pay: in_pay_i};

  mcr_table #(.DEPTH(DEPTH), .DW(NDEST), .KW(32)) u_table (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_key_i, .wr_mask_i, .wr_dest_i,
    .lk_key_i (in_key_i),
    .hit_o    (hit_vec),
    .rd_idx_i (hit_idx),
    .rd_dest_o(hit_dest)
  );

  mcr_prio #(.N(DEPTH)) u_prio (
    .clk_i, .rst_ni,
    .req_i(hit_vec),
    .any_o(hit_any),
    .idx_o(hit_idx)
  );

  assign in_ready_o = ~busy;
  assign accept     = in_valid_i & ~busy;

  // decision order: age, kind, parity, lookup
  always_comb begin
    route_sel  = '0;
    drop_age   = 1'b0;
    drop_par   = 1'b0;
    local_miss = 1'b0;
    miss_fwd   = 1'b0;
    if (is_stale(in_hdr_i[5:4], phase_i)) begin
      drop_age = 1'b1;
    end else if (pkt_kind_e'(in_hdr_i[7:6]) != PT_MC) begin
      route_sel[NDEST] = 1'b1;
    end else if (!parity_ok(in_pkt)) begin
      drop_par = 1'b1;
    end else if (hit_any) begin
      route_sel[NDEST-1:0] = hit_dest;
    end else if (in_src_i >= 3'd6) begin
      local_miss = 1'b1;
    end else begin
      route_sel[NUM_LINKS-1:0] = opposite(in_src_i);
      miss_fwd = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      par_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept && drop_age) age_q <= age_q + CNT_W'(1);
      if (accept && drop_par) par_q <= par_q + CNT_W'(1);
      err_q <= accept & local_miss;
    end
  end

  assign out_rdy = {byp_ready_i, dest_ready_i};

  mcr_outq #(.NO(NO)) u_outq (
    .clk_i, .rst_ni,
    .load_i    (accept),
    .load_sel_i(route_sel),
    .pkt_i     (in_pkt),
    .ready_i   (out_rdy),
    .valid_o   (out_vld),
    .pkt_o     (out_pkt),
    .busy_o    (busy)
  );

  assign dest_valid_o = out_vld[NDEST-1:0];
  assign byp_valid_o  = out_vld[NDEST];
  assign out_hdr_o    = out_pkt.hdr;
  assign out_key_o    = out_pkt.key;
  assign out_pay_o    = out_pkt.pay;
  assign err_o        = err_q;
  assign age_drops_o  = age_q;
  assign par_drops_o  = par_q;

  // R7
  miss_one_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && miss_fwd) |=> ($onehot(dest_valid_o) && !byp_valid_o));
  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (dest_valid_o == '0 && !byp_valid_o && in_ready_o));
  // R2
  age_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == $past(age_q)) || (age_q == $past(age_q) + CNT_W'(1)));
  // R3
  par_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_q == $past(par_q)) || (par_q == $past(par_q) + CNT_W'(1)));
endmodule

// File: tb/tb_mc_router.sv
`timescale 1ns/1ps
module tb_mc_router;
  localparam int DEPTH = 32;
  localparam int NC    = 4;
  localparam int ND    = 6 + NC;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [1:0]    phase_i;
  logic          wr_en_i, wr_valid_i;
  logic [4:0]    wr_idx_i;
  logic [31:0]   wr_key_i, wr_mask_i;
  logic [ND-1:0] wr_dest_i;
  logic          in_valid_i, in_ready_o;
  logic [2:0]    in_src_i;
  logic [7:0]    in_hdr_i, out_hdr_o;
  logic [31:0]   in_key_i, in_pay_i, out_key_o, out_pay_o;
  logic [ND-1:0] dest_valid_o, dest_ready_i;
  logic          byp_valid_o, byp_ready_i, err_o;
  logic [15:0]   age_drops_o, par_drops_o;

  always #4 clk = ~clk;

  mc_router #(.DEPTH(DEPTH), .NUM_CORES(NC), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni, .phase_i,
    .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_key_i, .wr_mask_i, .wr_dest_i,
    .in_valid_i, .in_ready_o, .in_src_i, .in_hdr_i, .in_key_i, .in_pay_i,
    .out_hdr_o, .out_key_o, .out_pay_o,
    .dest_valid_o, .dest_ready_i, .byp_valid_o, .byp_ready_i,
    .err_o, .age_drops_o, .par_drops_o
  );

  int n_tests = 0, n_fail = 0, age_exp = 0, par_exp = 0;
  logic [31:0]   r_key [DEPTH], r_mask [DEPTH];
  logic [ND-1:0] r_dest [DEPTH];
  logic          r_v [DEPTH];
  // staged same-cycle write
  logic          sw_en = 1'b0, sw_v;
  logic [4:0]    sw_idx;
  logic [31:0]   sw_key, sw_mask;
  logic [ND-1:0] sw_dest;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_hdr(input logic [1:0] kind, input logic [1:0] ts,
                                        input logic pf, input logic [31:0] key,
                                        input logic [31:0] pay, input logic bad);
    logic [7:0] h;
    logic p;
    h = {kind, ts, 2'b00, pf, 1'b0};
    p = ^{h, key, (pf ? pay : 32'h0)};
    h[0] = ~p ^ bad;
    return h;
  endfunction

  function automatic void predict(input logic [2:0] src, input logic [7:0] hdr,
                                  input logic [31:0] key, input logic [31:0] pay,
                                  input logic [1:0] ph, output logic [ND:0] sel,
                                  output logic e, output logic a, output logic p);
    logic [1:0] lim;
    int hit;
    sel = '0; e = 0; a = 0; p = 0;
    lim = ph + 2'd2;
    if (hdr[5:4] == lim) a = 1;
    else if (hdr[7:6] != 2'b00) sel[ND] = 1'b1;
    else if ($countones({hdr, key, (hdr[1] ? pay : 32'h0)}) % 2 == 0) p = 1;
    else begin
      hit = -1;
      for (int i = DEPTH - 1; i >= 0; i--)
        if (r_v[i] && (((key ^ r_key[i]) & r_mask[i]) == 32'h0)) hit = i;
      if (hit >= 0) sel[ND-1:0] = r_dest[hit];
      else if (src >= 3'd6) e = 1;
      else sel[(int'(src) + 3) % 6] = 1'b1;
    end
  endfunction

  task automatic wr(input int idx, input logic v, input logic [31:0] k,
                    input logic [31:0] m, input logic [ND-1:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = 5'(idx); wr_valid_i = v;
    wr_key_i = k; wr_mask_i = m; wr_dest_i = d;
    @(negedge clk);
    wr_en_i = 0;
    r_v[idx] = v; r_key[idx] = k; r_mask[idx] = m; r_dest[idx] = d;
  endtask

  task automatic send(input logic [2:0] src, input logic [7:0] hdr, input logic [31:0] key,
                      input logic [31:0] pay, input logic [1:0] ph, input string rq);
    logic [ND:0] sel, rem, rdy;
    logic e, a, p;
    int guard;
    predict(src, hdr, key, pay, ph, sel, e, a, p);
    @(negedge clk);
    chk({rq, " idle ready"}, 128'(in_ready_o), 128'(1));
    in_valid_i = 1; in_src_i = src; in_hdr_i = hdr; in_key_i = key; in_pay_i = pay;
    phase_i = ph; dest_ready_i = '0; byp_ready_i = 0;
    if (sw_en) begin
      wr_en_i = 1; wr_idx_i = sw_idx; wr_valid_i = sw_v;
      wr_key_i = sw_key; wr_mask_i = sw_mask; wr_dest_i = sw_dest;
    end
    @(negedge clk);
    in_valid_i = 0; wr_en_i = 0;
    if (sw_en) begin
      r_v[sw_idx] = sw_v; r_key[sw_idx] = sw_key;
      r_mask[sw_idx] = sw_mask; r_dest[sw_idx] = sw_dest;
      sw_en = 0;
    end
    if (a) age_exp++;
    if (p) par_exp++;
    chk({rq, " route"}, 128'({byp_valid_o, dest_valid_o}), 128'(sel));
    chk("R8 err pulse", 128'(err_o), 128'(e));
    chk("R2 age count", 128'(age_drops_o), 128'(16'(age_exp)));
    chk("R3 parity count", 128'(par_drops_o), 128'(16'(par_exp)));
    if (sel != '0) chk("R1 data", {out_hdr_o, out_key_o, out_pay_o}, {hdr, key, pay});
    else chk("R12 no stall on drop", 128'(in_ready_o), 128'(1));
    rem = sel; guard = 0;
    while (rem != '0) begin
      chk("R9 pending valids", 128'({byp_valid_o, dest_valid_o}), 128'(rem));
      chk("R9 stall", 128'(in_ready_o), 128'(0));
      chk("R9 data hold", {out_hdr_o, out_key_o, out_pay_o}, {hdr, key, pay});
      rdy = (guard > 6) ? '1 : (ND+1)'($urandom);
      dest_ready_i = rdy[ND-1:0]; byp_ready_i = rdy[ND];
      @(negedge clk);
      rem &= ~rdy; guard++;
    end
    dest_ready_i = '0; byp_ready_i = 0;
    if (sel != '0) begin
      chk("R9 all taken", 128'({byp_valid_o, dest_valid_o}), 128'(0));
      chk("R9 ready again", 128'(in_ready_o), 128'(1));
    end
    if (e) begin
      @(negedge clk);
      chk("R8 single pulse", 128'(err_o), 128'(0));
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] k, pl;
    logic [1:0]  ph, ts;
    logic [7:0]  h;
    int          ei;
    for (int i = 0; i < DEPTH; i++) begin
      r_v[i] = 0; r_key[i] = '0; r_mask[i] = '0; r_dest[i] = '0;
    end
    void'($urandom(32'd20240611));
    rst_ni = 0; phase_i = 0; wr_en_i = 0; wr_idx_i = 0; wr_valid_i = 0;
    wr_key_i = 0; wr_mask_i = 0; wr_dest_i = 0; in_valid_i = 0; in_src_i = 0;
    in_hdr_i = 0; in_key_i = 0; in_pay_i = 0; dest_ready_i = 0; byp_ready_i = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ready", 128'(in_ready_o), 128'(1));
    chk("R11 valids", 128'({byp_valid_o, dest_valid_o}), 128'(0));
    chk("R11 counters", 128'({age_drops_o, par_drops_o}), 128'(0));
    chk("R11 err", 128'(err_o), 128'(0));
    rst_ni = 1;

    // R11 empty table -> R7 opposite-link misses
    k = 32'hDEAD_0001; pl = 32'h1111_2222;
    send(3'd1, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R7 link1");
    send(3'd5, mk_hdr(2'b00, 2'd1, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R7 link5");
    // R8 local miss
    send(3'd7, mk_hdr(2'b00, 2'd0, 1'b0, k, pl, 1'b0), k, pl, 2'd0, "R8 local miss");

    wr(5, 1'b1, 32'h1234_5600, 32'hFFFF_FF00, 10'b01_0000_0001);
    wr(2, 1'b1, 32'h1234_0000, 32'hFFFF_0000, 10'b10_0010_0000);
    k = 32'h1234_56AB;
    send(3'd0, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R5 lowest wins");
    chk("R5 entry2 dests", 128'(dest_valid_o), 128'(0));
    wr(2, 1'b0, 32'h1234_0000, 32'hFFFF_0000, 10'b10_0010_0000);
    send(3'd6, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R4 invalid skipped");
    k = 32'h1234_56FF;
    send(3'd2, mk_hdr(2'b00, 2'd3, 1'b0, k, pl, 1'b0), k, pl, 2'd0, "R6 multi dest");
    k = 32'h1234_57AB;
    send(3'd0, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R4 cared bit miss");

    // R12 empty destination vector
    wr(9, 1'b1, 32'hAAAA_0000, 32'hFFFF_0000, '0);
    k = 32'hAAAA_1234;
    send(3'd3, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R12 zero dest");

    // R2 stale: phase 1 -> ts 3 is stale, any type
    send(3'd1, mk_hdr(2'b00, 2'd3, 1'b1, k, pl, 1'b0), k, pl, 2'd1, "R2 stale mc");
    send(3'd1, mk_hdr(2'b01, 2'd3, 1'b1, k, pl, 1'b1), k, pl, 2'd1, "R2 stale p2p");
    // R3 parity
    send(3'd1, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b1), k, pl, 2'd0, "R3 bad parity");
    h = mk_hdr(2'b00, 2'd0, 1'b0, k, 32'h0, 1'b0);
    send(3'd4, h, k, 32'h0000_0001, 2'd0, "R3 payload excluded");
    // R1 bypass kinds, parity not checked
    send(3'd2, mk_hdr(2'b01, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R1 p2p bypass");
    send(3'd7, mk_hdr(2'b10, 2'd1, 1'b0, k, pl, 1'b1), k, pl, 2'd0, "R1 nn bypass");
    send(3'd0, mk_hdr(2'b11, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd3, "R1 fr bypass");

    // R10 write in the same cycle as a lookup
    sw_en = 1; sw_idx = 5'd11; sw_v = 1; sw_key = 32'h5555_0000;
    sw_mask = 32'hFFFF_0000; sw_dest = 10'b10_0000_0000;
    k = 32'h5555_0001;
    send(3'd2, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R10 old contents");
    send(3'd2, mk_hdr(2'b00, 2'd0, 1'b1, k, pl, 1'b0), k, pl, 2'd0, "R10 new contents");

    // random table then random traffic
    for (int i = 0; i < DEPTH; i++)
      wr(i, ($urandom % 8) != 0, $urandom, ~(32'h1 << ($urandom % 32)) & ~(32'hF << ($urandom % 28)),
         ND'($urandom));
    for (int n = 0; n < 300; n++) begin
      ei = $urandom % DEPTH;
      if ($urandom % 10 < 7) k = r_key[ei] ^ ($urandom & ~r_mask[ei]);
      else k = $urandom;
      pl = $urandom; ph = 2'($urandom); ts = 2'($urandom);
      h = mk_hdr(($urandom % 6 == 0) ? 2'($urandom) : 2'b00, ts, 1'($urandom), k, pl,
                 ($urandom % 10) == 0);
      send(3'($urandom), h, k, pl, ph, "R6 random");
    end
    finish_run();
  end
endmodule